// File: doc/BRIEF.md
# Segment Table Address Translator

The block turns a logical address into a physical address. A logical address has two parts: a segment number and an offset inside that segment. The segment number picks one entry of a small segment table held in registers. Each entry describes one contiguous physical region. It holds a start address, a length, a valid bit and separate read, write and execute flags. The physical address is the entry's start address plus the offset.

Software fills the table through a single-cycle write port. The translation side takes a request: a segment number, an offset and an access type. The block accepts it when `req_valid` and `req_ready` are both high. One clock later it returns a one-cycle response. The response carries either the physical address or a fault with a two-bit cause.

Every translation checks three things: that the entry is valid, that the offset lies inside the segment's length, and that the access type is allowed by the entry's flags. A segment that software moves only needs its entry rewritten. Translations accepted after that write use the new start address.

Top module: `seg_xlate`

## Requirements
- R1: After reset every table entry is invalid, `rsp_valid` is low and `req_ready` is high.
- R2: When `wr_en` is high, the entry selected by `wr_seg` takes `wr_ent_valid`, `wr_base`, `wr_len` and `wr_perm` at the clock edge. The flag bits are: bit 0 allows read, bit 1 allows write and bit 2 allows execute. Translations accepted after the write use the new entry.
- R3: A translation that passes all checks returns `rsp_fault` = 0, `rsp_cause` = 00 and `rsp_paddr` equal to the entry's base plus the offset.
- R4: An offset greater than or equal to the entry's stored length faults with cause 10.
- R5: The access type is encoded as 00 read, 01 write, 10 instruction fetch and 11 reserved. A read needs flag bit 0, a write needs bit 1 and a fetch needs bit 2. A missing flag faults with cause 11. The reserved code always faults with cause 11.
- R6: A translation through an invalid entry faults with cause 01.
- R7: When more than one check fails, the cause reported follows a fixed priority. Invalid entry (01) wins over length (10), and length wins over permission (11).
- R8: If base plus offset is larger than the highest physical address, the access faults with cause 10 instead of wrapping around.
- R9: A request accepted on one rising edge produces `rsp_valid` high for exactly one cycle after that edge. No response appears without an accepted request.
- R10: `req_ready` is low in any cycle where `wr_en` is high. A request that meets a write to its own segment is therefore held for one cycle and then translated with the newly written entry.
- R11: Rewriting a valid entry with a new base moves every later translation of that segment to the new base.
- R12: A faulting response carries `rsp_paddr` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Table write strobe |
| wr_seg | input | 4 | Entry index to write |
| wr_ent_valid | input | 1 | Valid bit to store |
| wr_base | input | 24 | Physical start address to store |
| wr_len | input | 17 | Segment length in bytes to store |
| wr_perm | input | 3 | Flags to store: bit 0 read, bit 1 write, bit 2 execute |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_seg | input | 4 | Segment number of the request |
| req_off | input | 16 | Offset within the segment |
| req_acc | input | 2 | Access type: 00 read, 01 write, 10 fetch, 11 reserved |
| rsp_valid | output | 1 | Response present (one cycle) |
| rsp_paddr | output | 24 | Physical address; zero on a fault |
| rsp_fault | output | 1 | Translation faulted |
| rsp_cause | output | 2 | 00 none, 01 invalid entry, 10 length or overflow, 11 permission |

## Verification
Each table field shows up at the ports in a different way when it is wrong:

- A corrupted or stale base shows up as a wrong `rsp_paddr`, one cycle after the first accepted request to that segment.
- A wrong length or a missing carry check shows up as a wrong cause, either 00 or 10, on requests whose offsets sit next to the length boundary or the top of physical memory.
- A flipped flag or valid bit changes the cause between 00, 01 and 11 for the matching access type.
- A bad cause priority only appears when several checks fail together.
- A broken write-first stall shows up as the old base in the response that follows the write.

The bench therefore sweeps offsets around the length and the address ceiling, and mixes writes into the request stream.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_e;

  typedef enum logic [1:0] {
    CAUSE_NONE    = 2'b00,
    CAUSE_INVALID = 2'b01,
    CAUSE_BOUND   = 2'b10,
    CAUSE_PERM    = 2'b11
  } cause_e;

  localparam int PERM_W   = 3;
  localparam int PERM_RD  = 0;
  localparam int PERM_WR  = 1;
  localparam int PERM_EX  = 2;

  // Flag needed for a given access type; the reserved code never matches
  function automatic logic perm_allows(input logic [1:0] acc,
                                       input logic [PERM_W-1:0] perm);
    logic ok;
    case (acc)
      ACC_READ:  ok = perm[PERM_RD];
      ACC_WRITE: ok = perm[PERM_WR];
      ACC_FETCH: ok = perm[PERM_EX];
      default:   ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/seg_xlate_table.sv
module seg_xlate_table #(
  parameter int SEG_W = 4,
  parameter int PA_W  = 24,
  parameter int LEN_W = 17
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [SEG_W-1:0]                wr_seg,
  input  logic                            wr_ent_valid,
  input  logic [PA_W-1:0]                 wr_base,
  input  logic [LEN_W-1:0]                wr_len,
  input  logic [seg_xlate_pkg::PERM_W-1:0] wr_perm,
  input  logic [SEG_W-1:0]                rd_seg,
  output logic                            rd_valid,
  output logic [PA_W-1:0]                 rd_base,
  output logic [LEN_W-1:0]                rd_len,
  output logic [seg_xlate_pkg::PERM_W-1:0] rd_perm
);
  localparam int NSEG = 1 << SEG_W;
  localparam int PW   = seg_xlate_pkg::PERM_W;

  logic [NSEG-1:0]            valid_a;
  logic [NSEG-1:0][PA_W-1:0]  base_a;
  logic [NSEG-1:0][LEN_W-1:0] len_a;
  logic [NSEG-1:0][PW-1:0]    perm_a;

  for (genvar g = 0; g < NSEG; g++) begin : g_ent
    logic             sel;
    logic             v_q;
    logic [PA_W-1:0]  b_q;
    logic [LEN_W-1:0] l_q;
    logic [PW-1:0]    p_q;

    assign sel = wr_en && (wr_seg == SEG_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        b_q <= '0;
        l_q <= '0;
        p_q <= '0;
      end else if (sel) begin
        v_q <= wr_ent_valid;
        b_q <= wr_base;
        l_q <= wr_len;
        p_q <= wr_perm;
      end
    end

    assign valid_a[g] = v_q;
    assign base_a[g]  = b_q;
    assign len_a[g]   = l_q;
    assign perm_a[g]  = p_q;
  end

  assign rd_valid = valid_a[rd_seg];
  assign rd_base  = base_a[rd_seg];
  assign rd_len   = len_a[rd_seg];
  assign rd_perm  = perm_a[rd_seg];

endmodule

// File: rtl/seg_xlate_check.sv
module seg_xlate_check #(
  parameter int OFF_W = 16,
  parameter int PA_W  = 24,
  parameter int LEN_W = 17
) (
  input  logic                             ent_valid,
  input  logic [PA_W-1:0]                  ent_base,
  input  logic [LEN_W-1:0]                 ent_len,
  input  logic [seg_xlate_pkg::PERM_W-1:0] ent_perm,
  input  logic [OFF_W-1:0]                 off,
  input  logic [1:0]                       acc,
  output logic                             flt_invalid,
  output logic                             flt_bound,
  output logic                             flt_perm,
  output logic                             fault,
  output logic [1:0]                       cause,
  output logic [PA_W-1:0]                  paddr
);
  import seg_xlate_pkg::*;

  localparam int SUM_W = PA_W + 1;

  // Wide sum so a carry out of the physical range is visible
  function automatic logic [SUM_W-1:0] wide_sum(input logic [PA_W-1:0] b,
                                               input logic [OFF_W-1:0] o);
    return {1'b0, b} + SUM_W'(o);
  endfunction

  function automatic logic past_limit(input logic [OFF_W-1:0] o,
                                      input logic [LEN_W-1:0] l);
    return LEN_W'(o) >= l;
  endfunction

  logic [SUM_W-1:0] sum;
  logic             carry;

  assign sum         = wide_sum(ent_base, off);
  assign carry       = sum[PA_W];
  assign flt_invalid = !ent_valid;
  assign flt_bound   = past_limit(off, ent_len) || carry;
  assign flt_perm    = !perm_allows(acc, ent_perm);

  always_comb begin
    if (flt_invalid)      cause = CAUSE_INVALID;
    else if (flt_bound)   cause = CAUSE_BOUND;
    else if (flt_perm)    cause = CAUSE_PERM;
    else                  cause = CAUSE_NONE;
  end

  assign fault = (cause != CAUSE_NONE);
  assign paddr = fault ? '0 : sum[PA_W-1:0];

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int SEG_W = 4,
  parameter int OFF_W = 16,
  parameter int PA_W  = 24,
  parameter int LEN_W = OFF_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEG_W-1:0] wr_seg,
  input  logic             wr_ent_valid,
  input  logic [PA_W-1:0]  wr_base,
  input  logic [LEN_W-1:0] wr_len,
  input  logic [2:0]       wr_perm,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [SEG_W-1:0] req_seg,
  input  logic [OFF_W-1:0] req_off,
  input  logic [1:0]       req_acc,
  output logic             rsp_valid,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             rsp_fault,
  output logic [1:0]       rsp_cause
);
  localparam int PW = seg_xlate_pkg::PERM_W;

  logic             acc_fire;
  logic             ent_valid;
  logic [PA_W-1:0]  ent_base;
  logic [LEN_W-1:0] ent_len;
  logic [PW-1:0]    ent_perm;
  logic             flt_invalid;
  logic             flt_bound;
  logic             flt_perm;
  logic             nxt_fault;
  logic [1:0]       nxt_cause;
  logic [PA_W-1:0]  nxt_paddr;

  // Writes own the cycle; requests wait one clock and then see the new entry
  assign req_ready = !wr_en;
  assign acc_fire  = req_valid && req_ready;

  seg_xlate_table #(
    .SEG_W(SEG_W), .PA_W(PA_W), .LEN_W(LEN_W)
  ) u_table (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_seg       (wr_seg),
    .wr_ent_valid (wr_ent_valid),
    .wr_base      (wr_base),
    .wr_len       (wr_len),
    .wr_perm      (wr_perm),
    .rd_seg       (req_seg),
    .rd_valid     (ent_valid),
    .rd_base      (ent_base),
    .rd_len       (ent_len),
    .rd_perm      (ent_perm)
  );

  seg_xlate_check #(
    .OFF_W(OFF_W), .PA_W(PA_W), .LEN_W(LEN_W)
  ) u_check (
    .ent_valid   (ent_valid),
    .ent_base    (ent_base),
    .ent_len     (ent_len),
    .ent_perm    (ent_perm),
    .off         (req_off),
    .acc         (req_acc),
    .flt_invalid (flt_invalid),
    .flt_bound   (flt_bound),
    .flt_perm    (flt_perm),
    .fault       (nxt_fault),
    .cause       (nxt_cause),
    .paddr       (nxt_paddr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_cause <= '0;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= acc_fire;
      if (acc_fire) begin
        rsp_fault <= nxt_fault;
        rsp_cause <= nxt_cause;
        rsp_paddr <= nxt_paddr;
      end
    end
  end

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int PA_W = 24
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic            req_valid,
  input logic            acc_fire,
  input logic            ent_valid,
  input logic            flt_bound,
  input logic            flt_perm,
  input logic            rsp_valid,
  input logic            rsp_fault,
  input logic [1:0]      rsp_cause,
  input logic [PA_W-1:0] rsp_paddr
);
  // R9
  rsp_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire |=> rsp_valid);

  // R9
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_fire |=> !rsp_valid);

  // R6
  invalid_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire && !ent_valid |=> rsp_fault && rsp_cause == 2'b01);

  // R7
  bound_over_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire && ent_valid && flt_bound && flt_perm |=> rsp_cause == 2'b10);

  // R10
  write_stalls_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && req_valid |=> !rsp_valid);

  // R12
  fault_zero_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_paddr == '0);

  // R3
  pass_cause_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_fault |-> rsp_cause == 2'b00);

endmodule

bind seg_xlate seg_xlate_chk #(.PA_W(PA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .req_valid (req_valid),
  .acc_fire  (acc_fire),
  .ent_valid (ent_valid),
  .flt_bound (flt_bound),
  .flt_perm  (flt_perm),
  .rsp_valid (rsp_valid),
  .rsp_fault (rsp_fault),
  .rsp_cause (rsp_cause),
  .rsp_paddr (rsp_paddr)
);

// File: tb/seg_xlate_tb.sv
`timescale 1ns/1ps
module seg_xlate_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  wr_seg;
  logic        wr_ent_valid;
  logic [23:0] wr_base;
  logic [16:0] wr_len;
  logic [2:0]  wr_perm;
  logic        req_valid;
  logic        req_ready;
  logic [3:0]  req_seg;
  logic [15:0] req_off;
  logic [1:0]  req_acc;
  logic        rsp_valid;
  logic [23:0] rsp_paddr;
  logic        rsp_fault;
  logic [1:0]  rsp_cause;

  int n_chk = 0;
  int n_bad = 0;

  bit          m_v [16];
  logic [23:0] m_b [16];
  logic [16:0] m_l [16];
  logic [2:0]  m_p [16];

  always #4 clk = ~clk;

  seg_xlate u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_seg(wr_seg),
    .wr_ent_valid(wr_ent_valid), .wr_base(wr_base), .wr_len(wr_len),
    .wr_perm(wr_perm), .req_valid(req_valid), .req_ready(req_ready),
    .req_seg(req_seg), .req_off(req_off), .req_acc(req_acc),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .rsp_cause(rsp_cause)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected {fault, cause[1:0], paddr[23:0]}
  function automatic logic [26:0] model(input logic [3:0] s, input logic [15:0] o,
                                        input logic [1:0] a);
    logic [1:0] c;
    logic [31:0] sum;
    bit need;
    sum = {8'h0, m_b[s]} + {16'h0, o};
    case (a)
      2'b00: need = m_p[s][0];
      2'b01: need = m_p[s][1];
      2'b10: need = m_p[s][2];
      default: need = 1'b0;
    endcase
    if (!m_v[s])                                     c = 2'b01;
    else if ({1'b0, o} >= m_l[s] || sum > 32'hFFFFFF) c = 2'b10;
    else if (!need)                                  c = 2'b11;
    else                                             c = 2'b00;
    return (c != 2'b00) ? {1'b1, c, 24'h0} : {1'b0, c, sum[23:0]};
  endfunction

  task automatic wr_entry(input logic [3:0] s, input bit v, input logic [23:0] b,
                          input logic [16:0] l, input logic [2:0] p);
    @(negedge clk);
    wr_en = 1'b1; wr_seg = s; wr_ent_valid = v; wr_base = b; wr_len = l; wr_perm = p;
    @(negedge clk);
    wr_en = 1'b0;
    m_v[s] = v; m_b[s] = b; m_l[s] = l; m_p[s] = p;
  endtask

  task automatic xlate(input logic [3:0] s, input logic [15:0] o, input logic [1:0] a,
                       input string req);
    logic [26:0] e;
    @(negedge clk);
    req_valid = 1'b1; req_seg = s; req_off = o; req_acc = a;
    e = model(s, o, a);
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid === 1'b1, {req, " rsp_valid"}, longint'(rsp_valid), 1);
    check({rsp_fault, rsp_cause, rsp_paddr} === e, req,
          longint'({rsp_fault, rsp_cause, rsp_paddr}), longint'(e));
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [26:0] e;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) begin
      m_v[i] = 0; m_b[i] = '0; m_l[i] = '0; m_p[i] = '0;
    end
    rst_n = 1'b0; wr_en = 0; wr_seg = 0; wr_ent_valid = 0; wr_base = 0;
    wr_len = 0; wr_perm = 0; req_valid = 0; req_seg = 0; req_off = 0; req_acc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(rsp_valid === 1'b0, "R1 rsp_valid", longint'(rsp_valid), 0);
    check(req_ready === 1'b1, "R1 req_ready", longint'(req_ready), 1);
    xlate(4'd0, 16'h0, 2'b00, "R1 R6 reset entry invalid");
    // R9 no response without request
    @(negedge clk);
    check(rsp_valid === 1'b0, "R9 idle", longint'(rsp_valid), 0);

    // R2 R3 R4 R5
    wr_entry(4'd3, 1, 24'h100000, 17'h200, 3'b001);
    xlate(4'd3, 16'h01FF, 2'b00, "R3 last byte read");
    xlate(4'd3, 16'h0200, 2'b00, "R4 offset equals length");
    xlate(4'd3, 16'h0010, 2'b01, "R5 write without flag");
    xlate(4'd3, 16'h0010, 2'b10, "R5 fetch without flag");
    xlate(4'd3, 16'h0010, 2'b11, "R5 reserved access");
    xlate(4'd3, 16'h0300, 2'b01, "R7 length over permission");
    wr_entry(4'd7, 0, 24'h000000, 17'h0, 3'b000);
    xlate(4'd7, 16'hFFFF, 2'b11, "R7 invalid over all");
    wr_entry(4'd9, 1, 24'h000400, 17'h10000, 3'b110);
    xlate(4'd9, 16'hFFFF, 2'b10, "R2 full 64K fetch");
    xlate(4'd9, 16'h0000, 2'b00, "R5 read without flag");
    // R8 overflow
    wr_entry(4'd5, 1, 24'hFFFF00, 17'h10000, 3'b111);
    xlate(4'd5, 16'h00FF, 2'b00, "R8 top address");
    xlate(4'd5, 16'h0100, 2'b01, "R8 carry out");
    // R11 moved segment
    wr_entry(4'd3, 1, 24'h020000, 17'h200, 3'b001);
    xlate(4'd3, 16'h0005, 2'b00, "R11 new base");

    // R10 same-cycle write and request to the same segment
    @(negedge clk);
    wr_en = 1; wr_seg = 4'd3; wr_ent_valid = 1; wr_base = 24'h0ABC00;
    wr_len = 17'h400; wr_perm = 3'b011;
    req_valid = 1; req_seg = 4'd3; req_off = 16'h0300; req_acc = 2'b01;
    #1;
    check(req_ready === 1'b0, "R10 ready low", longint'(req_ready), 0);
    @(negedge clk);
    check(rsp_valid === 1'b0, "R10 stalled", longint'(rsp_valid), 0);
    wr_en = 0;
    m_v[3] = 1; m_b[3] = 24'h0ABC00; m_l[3] = 17'h400; m_p[3] = 3'b011;
    e = model(4'd3, 16'h0300, 2'b01);
    @(negedge clk);
    req_valid = 0;
    check(rsp_valid === 1'b1, "R10 rsp after stall", longint'(rsp_valid), 1);
    check({rsp_fault, rsp_cause, rsp_paddr} === e, "R10 write-first",
          longint'({rsp_fault, rsp_cause, rsp_paddr}), longint'(e));
    @(negedge clk);
    check(rsp_valid === 1'b0, "R9 single pulse", longint'(rsp_valid), 0);

    // Random mix R2 R3 R4 R5 R6 R8
    for (int it = 0; it < 600; it++) begin
      logic [3:0] s;
      logic [15:0] o;
      s = 4'($urandom_range(15));
      if ($urandom_range(7) == 0) begin
        logic [16:0] l;
        logic [23:0] b;
        l = ($urandom_range(3) == 0) ? 17'h10000 : 17'($urandom_range(17'h10000));
        b = ($urandom_range(3) == 0) ? 24'hFFFFFF - 24'($urandom_range(16'hFFFF))
                                     : 24'($urandom);
        wr_entry(s, $urandom_range(9) != 0, b, l, 3'($urandom_range(7)));
      end else begin
        case ($urandom_range(2))
          0: o = 16'($urandom);
          1: o = 16'(m_l[s] - 17'($urandom_range(2)));
          default: o = 16'(24'hFFFFFF - m_b[s] + 24'($urandom_range(2)) - 24'd1);
        endcase
        xlate(s, o, 2'($urandom_range(3)), "R2 R3 R4 R5 R6 R8 random");
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule